// File: doc/BRIEF.md
# Infrared SIR Transmit Framer

This block turns a frame, handed over one byte at a time, into the character stream that a slow-rate infrared link sends through an asynchronous serial transmitter. Before the frame it sends a run of start-of-frame characters. It then sends the payload with any reserved characters escaped, a 16-bit check value, and a closing end-of-frame character. Timing of the serial bits, baud generation and infrared pulse shaping are handled downstream.

The upstream side offers payload bytes with a valid/ready handshake. Each byte carries a last marker. The first byte of a frame also carries the number of extra leading start characters, or a flag saying that no number was given. A beat flagged as empty stands for a frame with no payload. The downstream side takes characters through its own valid/ready handshake and may stall at any time. A one-cycle completion pulse marks the end of each frame. Payload length is not limited, so frames of 2050 bytes and longer pass through.

Top module: `sir_tx_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid` and `frameDone` are 0 and `inReady` is 1.
- R2: A non-empty frame is emitted, in this order: N extra 0xC0 characters, one 0xC0, the escaped payload, the escaped 2-byte check value, and one 0xC1. Nothing else is emitted.
- R3: When `inCntSupplied` is 1 on the first beat, N is `inCnt` (8 bits). Any value above 163 gives N = 163.
- R4: When `inCntSupplied` is 0 on the first beat, N is 10 and `inCnt` is ignored.
- R5: A payload or check byte equal to 0xC0, 0xC1 or 0x7D is sent as 0x7D followed by the byte XOR 0x20. Every other byte is sent unchanged.
- R6: The check value is the reflected CRC-16 with polynomial 0x8408 and preset 0xFFFF, taken over the unescaped payload bytes and then inverted. It is sent low byte first, with each byte escaped per R5.
- R7: A beat accepted with `inEmpty` = 1 on a frame's first beat produces no characters. `frameDone` is 1 in the following cycle.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged in the next cycle.
- R9: `frameDone` is 1 for one cycle, in the cycle right after the closing 0xC1 is accepted (or per R7). It is never 1 at any other time.
- R10: `inReady` is never 1 while `outValid` is 1. A new frame is accepted only after the previous one has closed.
- R11: A 2050-byte payload is framed exactly as R2 describes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream beat valid |
| inReady | output | 1 | Framer can take a beat |
| inData | input | 8 | Payload byte |
| inLast | input | 1 | Beat holds the frame's last byte |
| inEmpty | input | 1 | First beat of an empty frame (no payload) |
| inCntSupplied | input | 1 | First beat carries an extra start count |
| inCnt | input | 8 | Requested extra start characters |
| outValid | output | 1 | Character valid toward the serial transmitter |
| outReady | input | 1 | Serial transmitter takes the character |
| outData | output | 8 | Framed character |
| frameDone | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the serial side may drop `outReady` in any cycle. They also assume the upstream side keeps `inValid` and its fields steady until the beat is taken, and raises `inEmpty` only on the first beat of a frame, together with `inLast`. The stimulus follows these rules. Inputs change only after a beat's acceptance has been seen, `inEmpty` is driven only by the empty-frame task, and the downstream ready comes from a random pattern or is held high. Checks on the ready-side hold, on escape pairing and on the cause of each completion pulse therefore rest only on those input rules.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

  // Which character the output multiplexer drives.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OPEN,
    SEL_CLOSE,
    SEL_ESCAPE,
    SEL_RAW,
    SEL_FLIPPED
  } charSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic     crcInit;
    logic     takeByte;
    logic     loadCnt;
    logic     decCnt;
    logic     loadCrcLo;
    logic     loadCrcHi;
    charSel_e sel;
  } dpCtl_t;

endpackage

// File: rtl/sir_tx_datapath.sv
module sir_tx_datapath
  import sir_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 8,
  parameter int CRC_W     = 16,
  parameter int MAX_EXTRA = 163,
  parameter int DEF_EXTRA = 10,
  parameter logic [BYTE_W-1:0] OPEN_CH  = 8'hC0,
  parameter logic [BYTE_W-1:0] CLOSE_CH = 8'hC1,
  parameter logic [BYTE_W-1:0] ESC_CH   = 8'h7D,
  parameter logic [BYTE_W-1:0] FLIP_MASK = 8'h20,
  parameter logic [CRC_W-1:0]  CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inCntSupplied,
  input  logic [CNT_W-1:0]  inCnt,
  output logic [BYTE_W-1:0] outData,
  output logic              needEsc,
  output logic              cntZero
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_EXTRA);
  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEF_EXTRA);

  logic [BYTE_W-1:0] holdByte;
  logic [CRC_W-1:0]  crcQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntLoad;

  // Bit-serial CRC unrolled over one byte.
  logic [CRC_W-1:0] crcChain [0:BYTE_W];

  assign crcChain[0] = (ctl.crcInit ? CRC_INIT : crcQ) ^ CRC_W'(inData);

  for (genvar k = 0; k < BYTE_W; k++) begin : g_crcBit
    assign crcChain[k+1] = crcChain[k][0] ? ((crcChain[k] >> 1) ^ CRC_POLY)
                                          : (crcChain[k] >> 1);
  end

  always_comb begin
    if (!inCntSupplied)       cntLoad = DEF_CNT;
    else if (inCnt > MAX_CNT) cntLoad = MAX_CNT;
    else                      cntLoad = inCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      crcQ     <= CRC_INIT;
      cntQ     <= '0;
    end else begin
      if (ctl.takeByte) begin
        holdByte <= inData;
        crcQ     <= crcChain[BYTE_W];
      end else if (ctl.loadCrcLo) begin
        holdByte <= ~crcQ[BYTE_W-1:0];
      end else if (ctl.loadCrcHi) begin
        holdByte <= ~crcQ[CRC_W-1:BYTE_W];
      end
      if (ctl.loadCnt)     cntQ <= cntLoad;
      else if (ctl.decCnt) cntQ <= cntQ - 1'b1;
    end
  end

  assign needEsc = (holdByte == OPEN_CH) || (holdByte == CLOSE_CH) ||
                   (holdByte == ESC_CH);
  assign cntZero = (cntQ == '0);

  always_comb begin
    unique case (ctl.sel)
      SEL_OPEN:    outData = OPEN_CH;
      SEL_CLOSE:   outData = CLOSE_CH;
      SEL_ESCAPE:  outData = ESC_CH;
      SEL_RAW:     outData = holdByte;
      SEL_FLIPPED: outData = holdByte ^ FLIP_MASK;
      default:     outData = '0;
    endcase
  end

endmodule

// File: rtl/sir_tx_ctrl.sv
module sir_tx_ctrl
  import sir_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   inEmpty,
  output logic   inReady,
  output logic   outValid,
  input  logic   outReady,
  input  logic   needEsc,
  input  logic   cntZero,
  output dpCtl_t ctl,
  output logic   frameDone
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BODY,
    ST_FLIP,
    ST_FETCH,
    ST_CLOSE
  } state_e;

  typedef enum logic [1:0] {
    PH_PAYLOAD,
    PH_CRC_LO,
    PH_CRC_HI
  } phase_e;

  state_e stateQ, stateD;
  phase_e phaseQ, phaseD;
  logic   lastQ, lastD;
  logic   doneQ, doneD;
  logic   byteSent;

  assign inReady  = (stateQ == ST_IDLE) || (stateQ == ST_FETCH);
  assign outValid = (stateQ == ST_OPEN) || (stateQ == ST_BODY) ||
                    (stateQ == ST_FLIP) || (stateQ == ST_CLOSE);

  // A held byte leaves the line when its last character is taken.
  assign byteSent = outReady &&
                    (((stateQ == ST_BODY) && !needEsc) || (stateQ == ST_FLIP));

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    lastD  = lastQ;
    doneD  = 1'b0;
    ctl    = '{crcInit: 1'b0, takeByte: 1'b0, loadCnt: 1'b0, decCnt: 1'b0,
               loadCrcLo: 1'b0, loadCrcHi: 1'b0, sel: SEL_NONE};

    unique case (stateQ)
      ST_IDLE: begin
        if (inValid) begin
          if (inEmpty) begin
            doneD = 1'b1;
          end else begin
            ctl.takeByte = 1'b1;
            ctl.crcInit  = 1'b1;
            ctl.loadCnt  = 1'b1;
            lastD        = inLast;
            phaseD       = PH_PAYLOAD;
            stateD       = ST_OPEN;
          end
        end
      end
      ST_OPEN: begin
        ctl.sel = SEL_OPEN;
        if (outReady) begin
          if (cntZero) stateD = ST_BODY;
          else         ctl.decCnt = 1'b1;
        end
      end
      ST_BODY: begin
        ctl.sel = needEsc ? SEL_ESCAPE : SEL_RAW;
        if (outReady && needEsc) stateD = ST_FLIP;
      end
      ST_FLIP: begin
        ctl.sel = SEL_FLIPPED;
      end
      ST_FETCH: begin
        if (inValid) begin
          ctl.takeByte = 1'b1;
          lastD        = inLast;
          stateD       = ST_BODY;
        end
      end
      ST_CLOSE: begin
        ctl.sel = SEL_CLOSE;
        if (outReady) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase

    if (byteSent) begin
      unique case (phaseQ)
        PH_PAYLOAD: begin
          if (lastQ) begin
            ctl.loadCrcLo = 1'b1;
            phaseD        = PH_CRC_LO;
            stateD        = ST_BODY;
          end else begin
            stateD = ST_FETCH;
          end
        end
        PH_CRC_LO: begin
          ctl.loadCrcHi = 1'b1;
          phaseD        = PH_CRC_HI;
          stateD        = ST_BODY;
        end
        default: stateD = ST_CLOSE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_PAYLOAD;
      lastQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      lastQ  <= lastD;
      doneQ  <= doneD;
    end
  end

  assign frameDone = doneQ;

endmodule

// File: rtl/sir_tx_framer.sv
module sir_tx_framer
  import sir_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 8,
  parameter int MAX_EXTRA = 163,
  parameter int DEF_EXTRA = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  input  logic              inEmpty,
  input  logic              inCntSupplied,
  input  logic [CNT_W-1:0]  inCnt,
  output logic              outValid,
  input  logic              outReady,
  output logic [BYTE_W-1:0] outData,
  output logic              frameDone
);

  dpCtl_t ctl;
  logic   needEsc;
  logic   cntZero;

  sir_tx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .inEmpty   (inEmpty),
    .inReady   (inReady),
    .outValid  (outValid),
    .outReady  (outReady),
    .needEsc   (needEsc),
    .cntZero   (cntZero),
    .ctl       (ctl),
    .frameDone (frameDone)
  );

  sir_tx_datapath #(
    .BYTE_W    (BYTE_W),
    .CNT_W     (CNT_W),
    .MAX_EXTRA (MAX_EXTRA),
    .DEF_EXTRA (DEF_EXTRA)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .inData        (inData),
    .inCntSupplied (inCntSupplied),
    .inCnt         (inCnt),
    .outData       (outData),
    .needEsc       (needEsc),
    .cntZero       (cntZero)
  );

endmodule

// File: rtl/sir_tx_checker.sv
module sir_tx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inEmpty,
  input logic              outValid,
  input logic              outReady,
  input logic [BYTE_W-1:0] outData,
  input logic              frameDone
);

  localparam logic [BYTE_W-1:0] OPEN_CH  = 8'hC0;
  localparam logic [BYTE_W-1:0] CLOSE_CH = 8'hC1;
  localparam logic [BYTE_W-1:0] ESC_CH   = 8'h7D;
  localparam logic [BYTE_W-1:0] FLIP     = 8'h20;

  // R8: a stalled character is held.
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R10: no upstream acceptance while a character is on the line.
  assert_idle_only_intake_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && inReady));

  // R5: an escape lead is followed by a flipped reserved character.
  assert_escape_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outData == ESC_CH) |=>
      (outValid && (((outData ^ FLIP) == OPEN_CH) || ((outData ^ FLIP) == CLOSE_CH) ||
                    ((outData ^ FLIP) == ESC_CH))));

  // R7: an empty frame completes in the next cycle.
  assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inEmpty) |=> frameDone);

  // R9: the close character being taken leads to the pulse.
  assert_close_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outData == CLOSE_CH) |=> frameDone);

  // R9: every pulse has a cause in the previous cycle.
  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(rstN) &&
      ($past(outValid && outReady && outData == CLOSE_CH) ||
       $past(inValid && inReady && inEmpty)));

endmodule

bind sir_tx_framer sir_tx_checker #(.BYTE_W(BYTE_W)) u_sirTxChecker (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .inEmpty   (inEmpty),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData),
  .frameDone (frameDone)
);

// File: tb/test_sir_tx_framer.sv
`timescale 1ns/1ps
module test_sir_tx_framer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0;
  logic       inEmpty = 1'b0;
  logic       inCntSupplied = 1'b0;
  logic [7:0] inCnt = '0;
  logic       outValid;
  logic       outReady = 1'b0;
  logic [7:0] outData;
  logic       frameDone;

  always #4 clk = ~clk;

  sir_tx_framer i_sir_tx_framer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inEmpty(inEmpty),
    .inCntSupplied(inCntSupplied), .inCnt(inCnt), .outValid(outValid),
    .outReady(outReady), .outData(outData), .frameDone(frameDone)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit readyAlways = 1'b0;
  bit running = 1'b0;

  byte unsigned expQ[$];
  string        tagQ[$];
  bit           endQ[$];

  bit  expDone = 1'b0;
  bit  prevStall = 1'b0;
  byte unsigned prevData = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crcStep(logic [15:0] c, byte unsigned b);
    logic [15:0] r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic bit isReserved(byte unsigned b);
    return (b == 8'hC0) || (b == 8'hC1) || (b == 8'h7D);
  endfunction

  task automatic pushChar(byte unsigned c, string tag, bit isEnd);
    expQ.push_back(c); tagQ.push_back(tag); endQ.push_back(isEnd);
  endtask

  task automatic pushEscaped(byte unsigned b, string tag);
    if (isReserved(b)) begin
      pushChar(8'h7D, "R5", 1'b0);
      pushChar(b ^ 8'h20, "R5", 1'b0);
    end else begin
      pushChar(b, tag, 1'b0);
    end
  endtask

  task automatic modelFrame(byte unsigned pay[$], bit sup, int cnt, string cntTag,
                            string payTag);
    int n;
    logic [15:0] crc = 16'hFFFF;
    n = sup ? ((cnt > 163) ? 163 : cnt) : 10;
    for (int i = 0; i < n; i++) pushChar(8'hC0, cntTag, 1'b0);
    pushChar(8'hC0, "R2", 1'b0);
    foreach (pay[i]) begin
      pushEscaped(pay[i], payTag);
      crc = crcStep(crc, pay[i]);
    end
    crc = ~crc;
    pushEscaped(crc[7:0], "R6");
    pushEscaped(crc[15:8], "R6");
    pushChar(8'hC1, "R2", 1'b1);
  endtask

  // Drive one upstream beat; returns after it has been taken.
  task automatic beat(byte unsigned d, bit last, bit empty, bit sup, byte unsigned cnt);
    inValid = 1'b1; inData = d; inLast = last; inEmpty = empty;
    inCntSupplied = sup; inCnt = cnt;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #2;
    inValid = 1'b0; inEmpty = 1'b0; inLast = 1'b0;
    inCntSupplied = 1'b0; inCnt = $urandom;
  endtask

  task automatic sendFrame(byte unsigned pay[$], bit sup, int cnt, string cntTag,
                           string payTag);
    modelFrame(pay, sup, cnt, cntTag, payTag);
    foreach (pay[i])
      beat(pay[i], i == pay.size() - 1, 1'b0, i == 0 ? sup : 1'b0,
           i == 0 ? 8'(cnt) : 8'($urandom));
  endtask

  task automatic sendEmpty();
    beat(8'h00, 1'b1, 1'b1, 1'b1, 8'd5);
  endtask

  always @(posedge clk) begin
    #2;
    outReady <= readyAlways ? 1'b1 : (($urandom % 10) < 7);
  end

  // Cycle-by-cycle comparison against the reference queues.
  always @(negedge clk) begin
    bit nextDone;
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (running) begin
      nextDone = 1'b0;
      check(frameDone == expDone, "R9", frameDone, expDone);
      check(!(outValid && inReady), "R10", inReady, 0);
      if (prevStall) begin
        check(outValid && outData == prevData, "R8", outData, prevData);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", outData, 0);
        end else begin
          check(outData == expQ[0], tagQ[0], outData, expQ[0]);
          nextDone = endQ[0];
          void'(expQ.pop_front()); void'(tagQ.pop_front()); void'(endQ.pop_front());
        end
      end
      if (inValid && inReady && inEmpty) nextDone = 1'b1;
      expDone   = nextDone;
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  initial begin
    byte unsigned pay[$];
    repeat (3) @(negedge clk);
    check(outValid == 0 && frameDone == 0 && inReady == 1, "R1",
          {outValid, frameDone, inReady}, 3'b001);
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && frameDone == 0 && inReady == 1, "R1",
          {outValid, frameDone, inReady}, 3'b001);
    running = 1'b1;
    @(posedge clk); #2;

    readyAlways = 1'b1;
    pay = '{8'h11, 8'h22, 8'h33};
    sendFrame(pay, 1'b1, 0, "R3", "R2");
    pay = '{8'hC0, 8'h05, 8'hC1, 8'h7D, 8'h20};
    sendFrame(pay, 1'b1, 2, "R3", "R5");
    sendEmpty();
    pay = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    sendFrame(pay, 1'b0, 0, "R4", "R6");
    readyAlways = 1'b0;
    pay = '{8'hAB};
    sendFrame(pay, 1'b1, 200, "R3", "R2");
    pay = '{8'h7D};
    sendFrame(pay, 1'b1, 163, "R3", "R5");
    pay = '{8'h01, 8'h02};
    sendFrame(pay, 1'b0, 255, "R4", "R2");
    sendEmpty();
    sendEmpty();

    for (int f = 0; f < 60; f++) begin
      int len = 1 + ($urandom % 24);
      pay.delete();
      for (int i = 0; i < len; i++) begin
        int r = $urandom % 8;
        pay.push_back(r == 0 ? 8'hC0 : r == 1 ? 8'hC1 : r == 2 ? 8'h7D : 8'($urandom));
      end
      readyAlways = (f % 3 == 0);
      sendFrame(pay, ($urandom % 2) == 1, $urandom % 256, "R3", "R6");
      if (f % 7 == 0) sendEmpty();
    end

    readyAlways = 1'b1;
    pay.delete();
    for (int i = 0; i < 2050; i++) pay.push_back(8'((i * 37 + 5) % 256));
    sendFrame(pay, 1'b1, 1, "R3", "R11");

    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0 && !outValid, "R2", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule